// File: doc/BRIEF.md
# Vectored Workspace Context-Switch Sequencer

This block performs the context change that a workspace-register processor needs for three kinds of event: a reset, a branch-with-workspace call, and an extended-operation (software trap) call. A single shared sequence serves all three. It fetches a new workspace pointer and a new program counter from a two-word vector. It then saves the caller's workspace pointer, program counter and status into the new workspace, and reports the resulting triple with a one-cycle completion pulse. The control unit supplies everything the sequence needs: the event kind, a trap number, an operand effective address, and the current pointer, counter and status. Decoding, address arithmetic for operands, and interrupt arbitration stay outside.

Requests enter on a valid/ready handshake. `start_ready` is high only while the sequencer is idle, and a request is taken in any cycle where both `start_valid` and `start_ready` are high. The request is not queued: a valid raised while ready is low is dropped, not stalled. Memory traffic uses a word-wide request/acknowledge port with at most one transfer in flight. A transfer is offered by holding `mem_req` high together with a steady address, direction and write data. It completes in the cycle in which `mem_ack` is high, and the memory may stretch it by any number of cycles. A spare kind code is run through the same path as the call kind, so a later interrupt source can reuse the sequence unchanged.

Top module: `ctx_switch_seq`

## Requirements
- R1: The vector address depends on the kind code `start_kind`. Code 0 (reset) uses address 0x0000. Code 1 (call) and code 3 (spare) use `start_opnd_ea`. Code 2 (trap) uses 0x0040 + 4*`start_xop_num`, which spans 0x0040 (number 0) to 0x007C (number 15).
- R2: The new workspace pointer is the word read at the vector address, and the new program counter is the word read at vector address + 2.
- R3: Memory accesses happen in this fixed order: read pointer, read counter, write old pointer to register 13, write old counter to register 14, write old status to register 15, and for the trap kind only, write register 11. Register k of a workspace sits at byte address new pointer + 2*k. Reset stops after the two reads. Call and spare stop after the register-15 write.
- R4: For the trap kind, the fourth write stores `start_opnd_ea` into register 11 of the new workspace.
- R5: The reported status is 0x0000 after reset, and unchanged after call or spare. After a trap it is the old status with bit 6 (value 0x0040, bit 0 being the least significant) set.
- R6: Only one memory transfer is outstanding at a time. While `mem_req` is high and `mem_ack` is low, the address, direction and write data do not change.
- R7: Every memory address has bit 0 forced to 0.
- R8: `done` is high for exactly one cycle, the cycle after the final acknowledge, and `mem_req` is low during it. `new_wp`, `new_pc` and `new_st` change only in a cycle where `done` is high, and hold their values until the next completion.
- R9: `start_ready` is high only while the sequencer is idle, and never together with `mem_req` or `done`. A request presented while `start_ready` is low has no effect on the accesses or the results.
- R10: After reset, `start_ready` is 1, `mem_req` and `done` are 0, and `new_wp`, `new_pc` and `new_st` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Switch request valid |
| start_ready | output | 1 | Sequencer idle, request can be taken |
| start_kind | input | 2 | 0 reset, 1 call, 2 trap, 3 spare |
| start_xop_num | input | 4 | Trap number |
| start_opnd_ea | input | 16 | Operand effective address (call vector or trap parameter) |
| cur_wp | input | 16 | Current workspace pointer |
| cur_pc | input | 16 | Current program counter |
| cur_st | input | 16 | Current status |
| mem_req | output | 1 | Memory transfer offered |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address, bit 0 always 0 |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Transfer completes this cycle |
| done | output | 1 | One-cycle completion pulse |
| new_wp | output | 16 | Resulting workspace pointer |
| new_pc | output | 16 | Resulting program counter |
| new_st | output | 16 | Resulting status |

## Verification
The bound checker watches the handshake discipline on every cycle. It checks that an offered transfer stays steady until acknowledged, that addresses are even, that the completion pulse lasts one cycle with no request beside it, that results move only with that pulse, and that readiness excludes activity. Whether the right words are read and written, in the right order and at the right workspace offsets, can only be shown by the bench's scenarios. The same holds for the trap vector arithmetic, the register-11 parameter store, the status rule per kind and the dropping of requests that arrive while busy. The bench compares each acknowledged transfer and each completion against a queue of predictions, under varied memory latency.

// File: rtl/ctx_switch_pkg.sv
package ctx_switch_pkg;

  typedef enum logic [1:0] {
    KIND_RESET = 2'd0,
    KIND_CALL  = 2'd1,
    KIND_TRAP  = 2'd2,
    KIND_SPARE = 2'd3
  } ctx_kind_e;

  typedef enum logic [2:0] {
    STEP_RD_WP    = 3'd0,
    STEP_RD_PC    = 3'd1,
    STEP_WR_OLDWP = 3'd2,
    STEP_WR_OLDPC = 3'd3,
    STEP_WR_OLDST = 3'd4,
    STEP_WR_PARAM = 3'd5
  } ctx_step_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_XFER  = 2'd2,
    SEQ_FIN   = 2'd3
  } ctx_seq_e;

  localparam int unsigned REG_OLDWP = 13;
  localparam int unsigned REG_OLDPC = 14;
  localparam int unsigned REG_OLDST = 15;
  localparam int unsigned REG_PARAM = 11;

  // Final step of the shared sequence for each kind
  function automatic ctx_step_e last_step_of(ctx_kind_e kind);
    case (kind)
      KIND_RESET: return STEP_RD_PC;
      KIND_TRAP:  return STEP_WR_PARAM;
      default:    return STEP_WR_OLDST;
    endcase
  endfunction

endpackage

// File: rtl/ctx_vec_addr.sv
module ctx_vec_addr
  import ctx_switch_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned NUM_W    = 4,
  parameter logic [W-1:0] TRAP_BASE = 16'h0040
) (
  input  ctx_kind_e        kind,
  input  logic [NUM_W-1:0] trap_num,
  input  logic [W-1:0]     opnd_ea,
  output logic [W-1:0]     vec_addr
);

  localparam int unsigned SLOT_SHIFT = 2;

  logic [W-1:0] trap_off;

  assign trap_off = W'({trap_num, {SLOT_SHIFT{1'b0}}});

  always_comb begin
    case (kind)
      KIND_RESET: vec_addr = '0;
      KIND_TRAP:  vec_addr = TRAP_BASE + trap_off;
      default:    vec_addr = opnd_ea;
    endcase
  end

endmodule

// File: rtl/ctx_step_plan.sv
module ctx_step_plan
  import ctx_switch_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  ctx_step_e    step,
  input  logic [W-1:0] vec_addr,
  input  logic [W-1:0] ws_ptr,
  input  logic [W-1:0] old_wp,
  input  logic [W-1:0] old_pc,
  input  logic [W-1:0] old_st,
  input  logic [W-1:0] param_ea,
  output logic         acc_we,
  output logic [W-1:0] acc_addr,
  output logic [W-1:0] acc_wdata
);

  localparam logic [W-1:0] OFF_PC    = W'(2);
  localparam logic [W-1:0] OFF_OLDWP = W'(2 * REG_OLDWP);
  localparam logic [W-1:0] OFF_OLDPC = W'(2 * REG_OLDPC);
  localparam logic [W-1:0] OFF_OLDST = W'(2 * REG_OLDST);
  localparam logic [W-1:0] OFF_PARAM = W'(2 * REG_PARAM);

  always_comb begin
    acc_we    = 1'b0;
    acc_addr  = vec_addr;
    acc_wdata = '0;
    case (step)
      STEP_RD_PC: acc_addr = vec_addr + OFF_PC;
      STEP_WR_OLDWP: begin
        acc_we    = 1'b1;
        acc_addr  = ws_ptr + OFF_OLDWP;
        acc_wdata = old_wp;
      end
      STEP_WR_OLDPC: begin
        acc_we    = 1'b1;
        acc_addr  = ws_ptr + OFF_OLDPC;
        acc_wdata = old_pc;
      end
      STEP_WR_OLDST: begin
        acc_we    = 1'b1;
        acc_addr  = ws_ptr + OFF_OLDST;
        acc_wdata = old_st;
      end
      STEP_WR_PARAM: begin
        acc_we    = 1'b1;
        acc_addr  = ws_ptr + OFF_PARAM;
        acc_wdata = param_ea;
      end
      default: acc_addr = vec_addr;
    endcase
  end

endmodule

// File: rtl/ctx_mem_if.sv
module ctx_mem_if #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic         we_in,
  input  logic [W-1:0] addr_in,
  input  logic [W-1:0] wdata_in,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (load) begin
      mem_req   <= 1'b1;
      mem_we    <= we_in;
      mem_addr  <= {addr_in[W-1:1], 1'b0};
      mem_wdata <= wdata_in;
    end else if (clear) begin
      mem_req   <= 1'b0;
    end
  end

endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
  import ctx_switch_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned NUM_W     = 4,
  parameter logic [W-1:0] TRAP_BASE = 16'h0040,
  parameter int unsigned TRAP_ST_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [1:0]       start_kind,
  input  logic [NUM_W-1:0] start_xop_num,
  input  logic [W-1:0]     start_opnd_ea,
  input  logic [W-1:0]     cur_wp,
  input  logic [W-1:0]     cur_pc,
  input  logic [W-1:0]     cur_st,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata,
  input  logic             mem_ack,
  output logic             done,
  output logic [W-1:0]     new_wp,
  output logic [W-1:0]     new_pc,
  output logic [W-1:0]     new_st
);

  localparam logic [W-1:0] TRAP_ST_MASK = W'(1) << TRAP_ST_BIT;

  ctx_seq_e  state_q;
  ctx_step_e step_q;
  ctx_kind_e kind_q;
  ctx_kind_e kind_in;
  logic [W-1:0] vec_q, old_wp_q, old_pc_q, old_st_q, param_q, st_res_q;
  logic [W-1:0] ws_q, pc_q;
  logic [W-1:0] out_wp_q, out_pc_q, out_st_q;

  logic [W-1:0] vec_in;
  logic [W-1:0] st_res_in;
  ctx_step_e    plan_step;
  logic         plan_we;
  logic [W-1:0] plan_addr, plan_wdata;
  logic         cur_last;
  logic         xfer_ack;
  logic         req_load, req_clear;

  assign kind_in = ctx_kind_e'(start_kind);

  ctx_vec_addr #(.W(W), .NUM_W(NUM_W), .TRAP_BASE(TRAP_BASE)) u_vec (
    .kind     (kind_in),
    .trap_num (start_xop_num),
    .opnd_ea  (start_opnd_ea),
    .vec_addr (vec_in)
  );

  always_comb begin
    case (kind_in)
      KIND_RESET: st_res_in = '0;
      KIND_TRAP:  st_res_in = cur_st | TRAP_ST_MASK;
      default:    st_res_in = cur_st;
    endcase
  end

  // Step offered next: the first one out of ISSUE, the successor otherwise
  assign plan_step = (state_q == SEQ_ISSUE) ? STEP_RD_WP : ctx_step_e'(step_q + 3'd1);
  assign cur_last  = (step_q == last_step_of(kind_q));
  assign xfer_ack  = (state_q == SEQ_XFER) && mem_ack;
  assign req_load  = (state_q == SEQ_ISSUE) || (xfer_ack && !cur_last);
  assign req_clear = xfer_ack && cur_last;

  ctx_step_plan #(.W(W)) u_plan (
    .step      (plan_step),
    .vec_addr  (vec_q),
    .ws_ptr    (ws_q),
    .old_wp    (old_wp_q),
    .old_pc    (old_pc_q),
    .old_st    (old_st_q),
    .param_ea  (param_q),
    .acc_we    (plan_we),
    .acc_addr  (plan_addr),
    .acc_wdata (plan_wdata)
  );

  ctx_mem_if #(.W(W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_load),
    .clear     (req_clear),
    .we_in     (plan_we),
    .addr_in   (plan_addr),
    .wdata_in  (plan_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      step_q   <= STEP_RD_WP;
      kind_q   <= KIND_RESET;
      vec_q    <= '0;
      old_wp_q <= '0;
      old_pc_q <= '0;
      old_st_q <= '0;
      param_q  <= '0;
      st_res_q <= '0;
      ws_q     <= '0;
      pc_q     <= '0;
      out_wp_q <= '0;
      out_pc_q <= '0;
      out_st_q <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_valid) begin
            kind_q   <= kind_in;
            vec_q    <= vec_in;
            old_wp_q <= cur_wp;
            old_pc_q <= cur_pc;
            old_st_q <= cur_st;
            param_q  <= start_opnd_ea;
            st_res_q <= st_res_in;
            state_q  <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: begin
          step_q  <= STEP_RD_WP;
          state_q <= SEQ_XFER;
        end
        SEQ_XFER: begin
          if (mem_ack) begin
            if (step_q == STEP_RD_WP) ws_q <= mem_rdata;
            if (step_q == STEP_RD_PC) pc_q <= mem_rdata;
            if (cur_last) begin
              out_wp_q <= ws_q;
              out_pc_q <= (step_q == STEP_RD_PC) ? mem_rdata : pc_q;
              out_st_q <= st_res_q;
              state_q  <= SEQ_FIN;
            end else begin
              step_q <= plan_step;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign start_ready = (state_q == SEQ_IDLE);
  assign done        = (state_q == SEQ_FIN);
  assign new_wp      = out_wp_q;
  assign new_pc      = out_pc_q;
  assign new_st      = out_st_q;

endmodule

// File: rtl/ctx_switch_seq_chk.sv
module ctx_switch_seq_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_ready,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_ack,
  input logic         done,
  input logic [W-1:0] new_wp,
  input logic [W-1:0] new_pc,
  input logic [W-1:0] new_st
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R6
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R8
  AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(new_wp) && $stable(new_pc) && $stable(new_st)) |-> done); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (!mem_req && !done)); // R9
  AST_ACK_AFTER_REQ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> done); // R8

endmodule

bind ctx_switch_seq ctx_switch_seq_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_ready (start_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .done        (done),
  .new_wp      (new_wp),
  .new_pc      (new_pc),
  .new_st      (new_st)
);

// File: tb/ctx_switch_seq_tb_top.sv
module ctx_switch_seq_tb_top;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
  } acc_t;

  typedef struct packed {
    logic [15:0] wp;
    logic [15:0] pc;
    logic [15:0] st;
  } res_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [1:0]  start_kind = '0;
  logic [3:0]  start_xop_num = '0;
  logic [15:0] start_opnd_ea = '0;
  logic [15:0] cur_wp = '0, cur_pc = '0, cur_st = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        done;
  logic [15:0] new_wp, new_pc, new_st;

  int vectors = 0;
  int misses  = 0;
  int done_cnt = 0;
  int lat = 0;
  int wait_cnt = 0;
  logic prev_done = 1'b0;

  logic [15:0] mem [int];
  acc_t exp_acc_q[$];
  res_t exp_res_q[$];

  always #2.5 clk = ~clk;

  ctx_switch_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_kind(start_kind), .start_xop_num(start_xop_num),
    .start_opnd_ea(start_opnd_ea),
    .cur_wp(cur_wp), .cur_pc(cur_pc), .cur_st(cur_st),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done), .new_wp(new_wp), .new_pc(new_pc), .new_st(new_st)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [15:0] a);
    int k = int'(a >> 1);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  // Memory model and access/result monitor (scoreboard consumer)
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (wait_cnt >= lat) begin
          acc_t e;
          wait_cnt = 0;
          if (exp_acc_q.size() == 0) begin
            chk("R3 unexpected access addr", mem_addr, 16'hxxxx);
          end else begin
            e = exp_acc_q.pop_front();
            chk("R3 access direction", {15'd0, mem_we}, {15'd0, e.we});
            chk("R3 access address", mem_addr, e.addr);
            if (mem_we) chk("R4 write data", mem_wdata, e.data);
          end
          if (mem_we) mem[int'(mem_addr >> 1)] = mem_wdata;
          else mem_rdata = rd(mem_addr);
          mem_ack = 1'b1;
        end else begin
          wait_cnt++;
        end
      end
      if (done) begin
        res_t r;
        chk("R8 done single cycle", {15'd0, prev_done}, 16'd0);
        chk("R3 all accesses made", 16'(exp_acc_q.size()), 16'd0);
        chk("R8 no request during done", {15'd0, mem_req}, 16'd0);
        if (exp_res_q.size() != 0) begin
          r = exp_res_q.pop_front();
          chk("R2 new wp", new_wp, r.wp);
          chk("R2 new pc", new_pc, r.pc);
          chk("R5 new st", new_st, r.st);
        end else begin
          chk("R8 unexpected done", 16'd1, 16'd0);
        end
        done_cnt++;
      end
      prev_done = done;
    end
  end

  // Driver: predicts accesses and result, then issues the request
  task automatic run_switch(input logic [1:0] kind, input logic [3:0] num,
                            input logic [15:0] ea, input logic [15:0] wp,
                            input logic [15:0] pc, input logic [15:0] st,
                            input logic [15:0] nwp, input logic [15:0] npc,
                            input int latency, input bit poke);
    logic [15:0] vec;
    logic [15:0] st_exp;
    int target;
    case (kind)
      2'd0: vec = 16'h0000;
      2'd2: vec = 16'h0040 + {10'd0, num, 2'b00};
      default: vec = ea & 16'hFFFE;
    endcase
    st_exp = (kind == 2'd0) ? 16'h0000 : (kind == 2'd2) ? (st | 16'h0040) : st;
    mem[int'(vec >> 1)] = nwp;
    mem[int'(vec >> 1) + 1] = npc;
    exp_acc_q.push_back('{1'b0, vec, nwp});
    exp_acc_q.push_back('{1'b0, vec + 16'd2, npc});
    if (kind != 2'd0) begin
      exp_acc_q.push_back('{1'b1, (nwp + 16'd26) & 16'hFFFE, wp});
      exp_acc_q.push_back('{1'b1, (nwp + 16'd28) & 16'hFFFE, pc});
      exp_acc_q.push_back('{1'b1, (nwp + 16'd30) & 16'hFFFE, st});
    end
    if (kind == 2'd2) exp_acc_q.push_back('{1'b1, (nwp + 16'd22) & 16'hFFFE, ea});
    exp_res_q.push_back('{nwp, npc, st_exp});
    lat = latency;
    target = done_cnt + 1;
    @(negedge clk);
    chk("R9 ready while idle", {15'd0, start_ready}, 16'd1);
    start_valid = 1'b1; start_kind = kind; start_xop_num = num;
    start_opnd_ea = ea; cur_wp = wp; cur_pc = pc; cur_st = st;
    @(negedge clk);
    start_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R9 not ready while busy", {15'd0, start_ready}, 16'd0);
      start_valid = 1'b1; start_kind = 2'd2; start_xop_num = 4'd9;
      start_opnd_ea = 16'hDEAD; cur_wp = 16'h1111; cur_pc = 16'h2222; cur_st = 16'h3333;
      repeat (2) @(negedge clk);
      start_valid = 1'b0;
    end
    wait (done_cnt == target);
    repeat (3) @(negedge clk);
    chk("R8 wp held after done", new_wp, nwp);
    chk("R8 pc held after done", new_pc, npc);
    chk("R8 st held after done", new_st, st_exp);
    chk("R9 no extra access after ignored start", 16'(exp_acc_q.size()), 16'd0);
    chk("R9 idle after done", {15'd0, mem_req}, 16'd0);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready after reset", {15'd0, start_ready}, 16'd1);
    chk("R10 req after reset", {15'd0, mem_req}, 16'd0);
    chk("R10 done after reset", {15'd0, done}, 16'd0);
    chk("R10 wp after reset", new_wp, 16'h0000);
    chk("R10 st after reset", new_st, 16'h0000);

    // R1 reset kind: two reads from 0x0000, status cleared
    run_switch(2'd0, 4'd0, 16'h0000, 16'h1000, 16'h2000, 16'hFFFF, 16'h83E0, 16'h0024, 0, 1'b0);
    // R1 call kind, vector from operand, status unchanged (R5)
    run_switch(2'd1, 4'd0, 16'h1234, 16'h83E0, 16'h0400, 16'hA5C3, 16'h8300, 16'h0600, 1, 1'b0);
    // R7 odd operand and odd workspace pointer
    run_switch(2'd1, 4'd0, 16'h2001, 16'h8300, 16'h0602, 16'h0001, 16'h4001, 16'h0700, 2, 1'b0);
    // R1 R4 R5 trap number 3 -> 0x004C
    run_switch(2'd2, 4'd3, 16'h5A5A, 16'h83E0, 16'h0810, 16'h0000, 16'h9000, 16'h0A00, 0, 1'b0);
    // R1 trap number 15 -> 0x007C, status bit already set
    run_switch(2'd2, 4'd15, 16'h0C0C, 16'h9000, 16'h0A02, 16'h0040, 16'hA000, 16'h0B00, 3, 1'b0);
    // R1 trap number 0 -> 0x0040, with ignored start while busy (R9)
    run_switch(2'd2, 4'd0, 16'h7777, 16'hA000, 16'h0B04, 16'h8000, 16'hB000, 16'h0C00, 2, 1'b1);
    // R1 spare kind follows the call path
    run_switch(2'd3, 4'd5, 16'h3000, 16'hB000, 16'h0C06, 16'h1234, 16'hC000, 16'h0D00, 1, 1'b0);
    // R9 ignored start during a call
    run_switch(2'd1, 4'd0, 16'h3100, 16'hC000, 16'h0D08, 16'h4321, 16'hD000, 16'h0E00, 1, 1'b1);
    finish_run();
  end

endmodule